// File: doc/BRIEF.md
# Coprocessor Usability Gating Unit

This block keeps the four coprocessor-usable bits of a processor status register and gives a verdict for every coprocessor instruction the decoder presents. A status write is filtered by a per-bit write mask. The mask is built from the per-coprocessor attachment straps and from an architecture-mode input. In modern mode a bit can only be set when its unit is present. In legacy mode every bit is writable, because external coprocessor chips may or may not be fitted. The current masked bits are always visible on a read port.

For each instruction the decoder supplies a class:

- the target coprocessor number;
- the operation kind;
- a flag marking an extended floating-point (COP1X) instruction;
- a flag marking a doubleword load/store major opcode.

One cycle later the block reports one of four verdicts: execute, no-op, force the destination to zero, or exception. An exception comes with a cause code and the offending coprocessor number.

An enabled unit that is absent never traps. Its stores and move-from transfers return zero, and everything else becomes a no-op. Software can therefore enable the floating-point unit, read its implementation register and find a zero ID, which tells it that no unit is fitted.

Two named states sequence the result. ST_IDLE means no result is on the outputs. ST_REPORT means a verdict is on the outputs for this cycle. The transitions are:

- ST_IDLE to ST_REPORT when an instruction is presented.
- ST_REPORT to ST_REPORT when another instruction follows at once.
- ST_REPORT to ST_IDLE when no instruction follows.

Top module: `cop_gate_top`

## Requirements
- R1: After reset, all four usable bits read 0 and `res_valid` is 0.
- R2: In modern mode (`arch_legacy`=0), a write of 1 sets bits 0, 1 and 2 only when the matching `attached_i` bit is 1. Otherwise the bit becomes 0. Without a write, the bits hold.
- R3: In modern mode, usable bit 3 can be set only when `attached_i[1]` is 1. Its own strap `attached_i[3]` only decides whether coprocessor 3 is present.
- R4: In legacy mode (`arch_legacy`=1), every usable bit takes the written value, whatever the straps are.
- R5: If no doubleword exception applies and the usable bit for the target is 0, the verdict is exception (`res_code`=3) with `exc_code`=11 and `exc_cop` equal to the coprocessor whose bit was checked.
- R6: A COP1X instruction ignores `ins_cop` and targets unit 1 for its presence check.
  - In modern mode it is enabled by usable bit 1; on failure `exc_cop`=1.
  - In legacy mode it is enabled by usable bit 3; on failure `exc_cop`=3.
- R7: If the checked bit is 1 but the unit's strap is 0, a store (`ins_kind`=1) or move-from (`ins_kind`=2) gets `res_code`=2 (zero the destination) and does not trap. This covers the implementation-register read of an absent floating-point unit.
- R8: If the checked bit is 1 but the unit is absent, any other kind (`ins_kind`=0 or 3) gets `res_code`=1 (no-op).
- R9: If the checked bit is 1 and the unit is present, the verdict is `res_code`=0 (execute).
- R10: When `isa_base`=1 and `ins_dword`=1, the verdict is a reserved-instruction exception: `res_code`=3, `exc_code`=10, `exc_cop`=0. This takes priority over the usable-bit check.
- R11: Each cycle with `ins_valid`=1 produces exactly one cycle of `res_valid`=1 on the next cycle, and back-to-back instructions are accepted. An instruction is judged against the usable bits held before any status write in the same cycle.
- R12: Whenever the verdict is not an exception, `exc_code` and `exc_cop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arch_legacy | input | 1 | 1 = legacy architecture mode, 0 = modern |
| isa_base | input | 1 | 1 = lowest ISA level |
| attached_i | input | 4 | Per-coprocessor presence straps; bit 0 is the system unit, normally tied 1 |
| sr_wr_en | input | 1 | Status write strobe |
| sr_wr_data | input | 4 | Usable bits to write |
| sr_rd_data | output | 4 | Masked usable bits currently held |
| ins_valid | input | 1 | Instruction class present this cycle |
| ins_cop | input | 2 | Target coprocessor number |
| ins_kind | input | 2 | 0 other, 1 store, 2 move-from, 3 other |
| ins_cop1x | input | 1 | Extended floating-point instruction |
| ins_dword | input | 1 | Doubleword load/store major opcode |
| res_valid | output | 1 | Verdict valid strobe |
| res_code | output | 2 | 0 execute, 1 no-op, 2 zero destination, 3 exception |
| exc_code | output | 5 | 10 reserved instruction, 11 coprocessor unusable, else 0 |
| exc_cop | output | 2 | Coprocessor named by an unusable exception |

## Verification
A wrongly masked usable bit shows up on `sr_rd_data` on the cycle after the write. It then shows up again in the verdict of the next instruction aimed at that coprocessor, as a trap where a zero or no-op was due, or the reverse. A wrong sequencer state shows up one cycle after an instruction, as a missing, doubled or spurious `res_valid` pulse. The scoreboard catches this because it expects exactly one verdict per instruction, in order.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    localparam int NCOP  = 4;
    localparam int CW    = $clog2(NCOP);
    localparam int EXC_W = 5;

    localparam logic [EXC_W-1:0] EXC_NONE = 5'd0;
    localparam logic [EXC_W-1:0] EXC_RI   = 5'd10;
    localparam logic [EXC_W-1:0] EXC_CPU  = 5'd11;

    typedef enum logic [1:0] {
        RES_EXEC = 2'd0,
        RES_NOP  = 2'd1,
        RES_ZERO = 2'd2,
        RES_EXC  = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        KIND_OTHER = 2'd0,
        KIND_STORE = 2'd1,
        KIND_MFROM = 2'd2,
        KIND_SPARE = 2'd3
    } kind_e;

    typedef struct packed {
        res_e              res;
        logic [EXC_W-1:0]  code;
        logic [CW-1:0]     cop;
    } verdict_t;

endpackage

// File: rtl/cpg_usable_reg.sv
module cpg_usable_reg
    import cpg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            legacy,
    input  logic [NCOP-1:0] attached,
    input  logic            wr_en,
    input  logic [NCOP-1:0] wr_data,
    output logic [NCOP-1:0] usable
);

    logic [NCOP-1:0] allow;

    // Unit 3 keeps its bit only as a compatibility flag; its right to be set
    // follows the floating-point unit strap. All other bits follow their own.
    for (genvar i = 0; i < NCOP; i++) begin : g_mask
        localparam int SRC = (i == 3) ? 1 : i;
        assign allow[i] = legacy | attached[SRC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            usable <= '0;
        end else if (wr_en) begin
            usable <= wr_data & allow;
        end
    end

endmodule

// File: rtl/cpg_classify.sv
module cpg_classify
    import cpg_pkg::*;
(
    input  logic            legacy,
    input  logic            isa_base,
    input  logic [NCOP-1:0] usable,
    input  logic [NCOP-1:0] attached,
    input  logic [CW-1:0]   cop,
    input  kind_e           kind,
    input  logic            cop1x,
    input  logic            dword,
    output verdict_t        verdict
);

    logic [CW-1:0] en_idx;
    logic [CW-1:0] unit_idx;
    logic          writes_dest;

    always_comb begin
        // Extended FP ops always target unit 1 but are gated by a mode-chosen bit.
        if (cop1x) begin
            en_idx   = legacy ? CW'(3) : CW'(1);
            unit_idx = CW'(1);
        end else begin
            en_idx   = cop;
            unit_idx = cop;
        end
        writes_dest = (kind == KIND_STORE) || (kind == KIND_MFROM);
    end

    always_comb begin
        verdict.res  = RES_EXEC;
        verdict.code = EXC_NONE;
        verdict.cop  = '0;
        if (isa_base && dword) begin
            verdict.res  = RES_EXC;
            verdict.code = EXC_RI;
        end else if (!usable[en_idx]) begin
            verdict.res  = RES_EXC;
            verdict.code = EXC_CPU;
            verdict.cop  = en_idx;
        end else if (!attached[unit_idx]) begin
            verdict.res  = writes_dest ? RES_ZERO : RES_NOP;
        end
    end

endmodule

// File: rtl/cpg_report.sv
module cpg_report
    import cpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  verdict_t         verdict,
    output logic             res_valid,
    output logic [1:0]       res_code,
    output logic [EXC_W-1:0] exc_code,
    output logic [CW-1:0]    exc_cop
);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;

    state_e   state_q, state_d;
    verdict_t held_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ins_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = ins_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (ins_valid) begin
            held_q <= verdict;
        end else begin
            held_q <= '0;
        end
    end

    always_comb begin
        res_valid = (state_q == ST_REPORT);
        res_code  = held_q.res;
        exc_code  = held_q.code;
        exc_cop   = held_q.cop;
    end

endmodule

// File: rtl/cop_gate_top.sv
module cop_gate_top
    import cpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arch_legacy,
    input  logic             isa_base,
    input  logic [NCOP-1:0]  attached_i,
    input  logic             sr_wr_en,
    input  logic [NCOP-1:0]  sr_wr_data,
    output logic [NCOP-1:0]  sr_rd_data,
    input  logic             ins_valid,
    input  logic [CW-1:0]    ins_cop,
    input  logic [1:0]       ins_kind,
    input  logic             ins_cop1x,
    input  logic             ins_dword,
    output logic             res_valid,
    output logic [1:0]       res_code,
    output logic [EXC_W-1:0] exc_code,
    output logic [CW-1:0]    exc_cop
);

    logic [NCOP-1:0] usable;
    verdict_t        verdict;

    cpg_usable_reg u_usable (
        .clk      (clk),
        .rst_n    (rst_n),
        .legacy   (arch_legacy),
        .attached (attached_i),
        .wr_en    (sr_wr_en),
        .wr_data  (sr_wr_data),
        .usable   (usable)
    );

    cpg_classify u_classify (
        .legacy   (arch_legacy),
        .isa_base (isa_base),
        .usable   (usable),
        .attached (attached_i),
        .cop      (ins_cop),
        .kind     (kind_e'(ins_kind)),
        .cop1x    (ins_cop1x),
        .dword    (ins_dword),
        .verdict  (verdict)
    );

    cpg_report u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .verdict   (verdict),
        .res_valid (res_valid),
        .res_code  (res_code),
        .exc_code  (exc_code),
        .exc_cop   (exc_cop)
    );

    assign sr_rd_data = usable;

endmodule

// File: rtl/cpg_checker.sv
module cpg_checker
    import cpg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             arch_legacy,
    input logic             isa_base,
    input logic [NCOP-1:0]  attached_i,
    input logic             sr_wr_en,
    input logic [NCOP-1:0]  sr_wr_data,
    input logic [NCOP-1:0]  sr_rd_data,
    input logic             ins_valid,
    input logic [CW-1:0]    ins_cop,
    input logic             ins_cop1x,
    input logic             ins_dword,
    input logic             res_valid,
    input logic [1:0]       res_code,
    input logic [EXC_W-1:0] exc_code,
    input logic [CW-1:0]    exc_cop
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && sr_rd_data == '0));

    p_cu1_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && !arch_legacy && !attached_i[1]) |=> !sr_rd_data[1]);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_en |=> $stable(sr_rd_data));

    p_cu3_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && !arch_legacy && !attached_i[1]) |=> !sr_rd_data[3]);

    p_legacy_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && arch_legacy) |=> sr_rd_data == $past(sr_wr_data));

    p_unusable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !(isa_base && ins_dword) && !ins_cop1x && !sr_rd_data[ins_cop])
        |=> (res_code == 2'd3 && exc_code == 5'd11 && exc_cop == $past(ins_cop)));

    p_ri_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && isa_base && ins_dword)
        |=> (res_code == 2'd3 && exc_code == 5'd10 && exc_cop == '0));

    p_res_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> res_valid);

    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> !res_valid);

    p_code_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code != 2'd3) |-> (exc_code == '0 && exc_cop == '0));

endmodule

bind cop_gate_top cpg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arch_legacy (arch_legacy),
    .isa_base    (isa_base),
    .attached_i  (attached_i),
    .sr_wr_en    (sr_wr_en),
    .sr_wr_data  (sr_wr_data),
    .sr_rd_data  (sr_rd_data),
    .ins_valid   (ins_valid),
    .ins_cop     (ins_cop),
    .ins_cop1x   (ins_cop1x),
    .ins_dword   (ins_dword),
    .res_valid   (res_valid),
    .res_code    (res_code),
    .exc_code    (exc_code),
    .exc_cop     (exc_cop)
);

// File: tb/sim_cop_gate_top.sv
`timescale 1ns/1ps
module sim_cop_gate_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arch_legacy = 1'b0;
    logic       isa_base = 1'b0;
    logic [3:0] attached_i = 4'b0001;
    logic       sr_wr_en = 1'b0;
    logic [3:0] sr_wr_data = '0;
    logic [3:0] sr_rd_data;
    logic       ins_valid = 1'b0;
    logic [1:0] ins_cop = '0;
    logic [1:0] ins_kind = '0;
    logic       ins_cop1x = 1'b0;
    logic       ins_dword = 1'b0;
    logic       res_valid;
    logic [1:0] res_code;
    logic [4:0] exc_code;
    logic [1:0] exc_cop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] res;
        logic [4:0] code;
        logic [1:0] cop;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    cop_gate_top u0 (
        .clk(clk), .rst_n(rst_n), .arch_legacy(arch_legacy), .isa_base(isa_base),
        .attached_i(attached_i), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .sr_rd_data(sr_rd_data), .ins_valid(ins_valid), .ins_cop(ins_cop),
        .ins_kind(ins_kind), .ins_cop1x(ins_cop1x), .ins_dword(ins_dword),
        .res_valid(res_valid), .res_code(res_code), .exc_code(exc_code),
        .exc_cop(exc_cop)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: one verdict per res_valid pulse, popped in order.
    always @(negedge clk) begin
        if (rst_n && res_valid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 spurious res_valid", {25'd0, res_code, exc_code}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_code == e.res && exc_code == e.code && exc_cop == e.cop, e.tag,
                      {23'd0, res_code, exc_code, exc_cop}, {23'd0, e.res, e.code, e.cop});
            end
        end
    end

    task automatic issue(input logic [1:0] cop, input logic [1:0] kind, input logic x,
                         input logic d, input logic [1:0] er, input logic [4:0] ec,
                         input logic [1:0] ecop, input string tag);
        exp_t e;
        @(negedge clk);
        ins_valid = 1'b1; ins_cop = cop; ins_kind = kind; ins_cop1x = x; ins_dword = d;
        e.res = er; e.code = ec; e.cop = ecop; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        ins_valid = 1'b0; ins_cop1x = 1'b0; ins_dword = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic write_sr(input logic [3:0] d, input logic [3:0] expv, input string tag);
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = d;
        @(negedge clk);
        sr_wr_en = 1'b0;
        check(sr_rd_data == expv, tag, {28'd0, sr_rd_data}, {28'd0, expv});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sr_rd_data == 4'b0000, "R1 usable bits after reset", {28'd0, sr_rd_data}, 0);
        check(res_valid == 1'b0, "R1 res_valid after reset", {31'd0, res_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Modern mode, only the system unit present.
        arch_legacy = 1'b0; attached_i = 4'b0001;
        write_sr(4'b1111, 4'b0001, "R2 R3 modern mask with absent units");
        issue(2'd0, 2'd0, 0, 0, 2'd0, 5'd0,  2'd0, "R9 system unit executes");
        issue(2'd1, 2'd0, 0, 0, 2'd3, 5'd11, 2'd1, "R5 cop1 unusable");
        issue(2'd2, 2'd1, 0, 0, 2'd3, 5'd11, 2'd2, "R5 cop2 store unusable");
        issue(2'd3, 2'd2, 0, 0, 2'd3, 5'd11, 2'd3, "R5 cop3 move-from unusable");
        issue(2'd2, 2'd0, 1, 0, 2'd3, 5'd11, 2'd1, "R6 modern cop1x gated by bit 1");
        idle(0);
        isa_base = 1'b1;
        issue(2'd0, 2'd1, 0, 1, 2'd3, 5'd10, 2'd0, "R10 doubleword at base ISA");
        idle(2);
        isa_base = 1'b0;

        // Legacy mode: all bits writable, absent units gated softly.
        arch_legacy = 1'b1;
        write_sr(4'b1110, 4'b1110, "R4 legacy write ignores straps");
        issue(2'd1, 2'd2, 0, 0, 2'd2, 5'd0, 2'd0, "R7 absent FPU implementation read gives zero");
        issue(2'd1, 2'd1, 0, 0, 2'd2, 5'd0, 2'd0, "R7 absent unit store zeroes");
        issue(2'd2, 2'd0, 0, 0, 2'd1, 5'd0, 2'd0, "R8 absent unit other is no-op");
        issue(2'd1, 2'd3, 0, 0, 2'd1, 5'd0, 2'd0, "R8 kind 3 on absent unit is no-op");
        issue(2'd0, 2'd0, 1, 0, 2'd1, 5'd0, 2'd0, "R6 legacy cop1x enabled by bit 3");
        issue(2'd0, 2'd0, 0, 0, 2'd3, 5'd11, 2'd0, "R5 legacy cop0 bit cleared");
        idle(1);
        write_sr(4'b0111, 4'b0111, "R4 legacy write clears bit 3");
        issue(2'd1, 2'd0, 1, 0, 2'd3, 5'd11, 2'd3, "R6 legacy cop1x names unit 3");
        issue(2'd1, 2'd0, 0, 0, 2'd1, 5'd0, 2'd0, "R8 cop1 still no-op");
        idle(2);

        // Modern mode with the floating-point unit present.
        arch_legacy = 1'b0; attached_i = 4'b0011;
        write_sr(4'b1111, 4'b1011, "R3 bit 3 follows cop1 strap, R2 bit 2 masked");
        issue(2'd1, 2'd0, 0, 0, 2'd0, 5'd0,  2'd0, "R9 present cop1 executes");
        issue(2'd0, 2'd1, 1, 0, 2'd0, 5'd0,  2'd0, "R6 cop1x store executes");
        issue(2'd3, 2'd0, 0, 0, 2'd1, 5'd0,  2'd0, "R3 cop3 enabled but absent no-op");
        issue(2'd2, 2'd2, 0, 0, 2'd3, 5'd11, 2'd2, "R5 cop2 masked off traps");
        idle(1);
        write_sr(4'b0001, 4'b0001, "R2 modern write clears bits");
        issue(2'd0, 2'd1, 1, 0, 2'd3, 5'd11, 2'd1, "R6 modern cop1x unusable");
        issue(2'd1, 2'd1, 0, 1, 2'd3, 5'd11, 2'd1, "R5 doubleword above base ISA");
        idle(0);
        isa_base = 1'b1;
        issue(2'd1, 2'd1, 0, 1, 2'd3, 5'd10, 2'd0, "R10 reserved before unusable");
        idle(1);
        isa_base = 1'b0;

        // Same-cycle write and instruction: old bits judge the instruction.
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = 4'b0011;
        begin
            exp_t e;
            ins_valid = 1'b1; ins_cop = 2'd1; ins_kind = 2'd0; ins_cop1x = 0; ins_dword = 0;
            e.res = 2'd3; e.code = 5'd11; e.cop = 2'd1; e.tag = "R11 old bits used on same-cycle write";
            exp_q.push_back(e);
        end
        @(negedge clk);
        sr_wr_en = 1'b0;
        begin
            exp_t e;
            ins_cop = 2'd1; ins_dword = 1'b1;
            e.res = 2'd0; e.code = 5'd0; e.cop = 2'd0; e.tag = "R11 next instruction sees new bits";
            exp_q.push_back(e);
        end
        idle(3);
        check(sr_rd_data == 4'b0011, "R2 bits after same-cycle write", {28'd0, sr_rd_data}, 32'h3);
        check(exp_q.size() == 0, "R11 every instruction answered", exp_q.size(), 0);
        check(res_valid == 1'b0, "R11 no result when idle", {31'd0, res_valid}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule